// File: doc/BRIEF.md
# Prioritised 64-Source Interrupt Controller Core

This block gathers 64 level-sensitive interrupt lines and turns them into two requests for a processor: a normal request and a fast request. Each source has four pieces of state: a pending bit, an enable bit, a type bit that sends it to the fast request, and a 4-bit priority. A 5-bit threshold decides which normal sources may raise the normal request. Software reaches this state through a 32-bit, word-addressed register port. The port has separate read and write strobes, and every access completes in one cycle.

A pending bit takes on a source's level when that line changes. Software can also overwrite the pending bits through a pair of force words, and the forced value stays until the line next changes. Enables are set or cleared one at a time by writing a source number. They can also be written as whole 32-bit halves. Priorities are held eight to a word. The lookup that turns a request into a vector is done by a separate resolver. This core supplies only the pending views that the resolver needs.

Top module: `irq_prio_core`

## Requirements
- R1: A source's pending bit takes the new level of its input in the clock edge at which the input is first seen changed; with no change and no force write it holds.
- R2: Writing word offset 2 sets the enable bit of the source numbered by wdata[5:0], and writing offset 3 clears it. Both offsets read as zero.
- R3: Enable (offsets 4 high / 5 low), type (6 / 7) and force (20 / 21) are split into halves: high holds sources 63..32, low holds 31..0. A write to one half leaves the other half as it was.
- R4: A type bit of 1 routes its source to the fast output. The fast output is the OR over all sources of pending AND enabled AND type.
- R5: The threshold (offset 1, bits 4:0) at 0x1F bypasses priority: the normal output is the OR of pending AND enabled AND NOT type.
- R6: Below 0x1F, the normal output is high only if some pending, enabled normal source has a priority strictly greater than the threshold.
- R7: Priority words sit at offsets 8..15 in reverse order: offset 15 holds sources 7..0 and offset 8 holds sources 63..56, with source s in bits 4*(s%8)+3 : 4*(s%8).
- R8: A write to a force word overwrites that half of the pending bits. The force words read as zero.
- R9: After reset, pending, enables, types and priorities are zero and the threshold reads 0x1F.
- R10: Read-only views of the pending state ignore writes: raw pending (18 / 19), pending AND enabled AND normal (22 / 23), and pending AND enabled AND fast (24 / 25).
- R11: Unmapped offsets, 0 among them, read as zero, and writes to them change nothing.
- R12: Both outputs are registered. Each changes one clock edge after the state it depends on, and read data appears in the edge that samples the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 64 | Interrupt source levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, held between reads |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The routing is tried with a single source in three setups: marked normal, marked fast, and normal but disabled. This tells a type fault apart from an enable fault. The threshold is swept past a fixed priority at several points: below it, equal to it, above it, at a value no priority can beat, and at the bypass code. Each step isolates strict-greater comparison from greater-or-equal and from the bypass. A source in the top priority word is compared against one in the bottom word, which exposes a non-reversed word map. Forced pending bits are then overwritten through the read-only views and unmapped offsets, which shows whether any stray write leaks into the state.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
  localparam int DATA_W        = 32;
  localparam int NUM_SRC       = 2 * DATA_W;
  localparam int PRIO_W        = 4;
  localparam int THR_W         = 5;
  localparam int ADDR_W        = 6;
  localparam int SRC_IDX_W     = $clog2(NUM_SRC);
  localparam int PRIO_PER_WORD = DATA_W / PRIO_W;
  localparam int PRIO_WORDS    = NUM_SRC / PRIO_PER_WORD;

  localparam logic [THR_W-1:0] THR_BYPASS = {THR_W{1'b1}};

  localparam logic [ADDR_W-1:0] OFF_THR      = 6'd1;
  localparam logic [ADDR_W-1:0] OFF_EN_SET   = 6'd2;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR   = 6'd3;
  localparam logic [ADDR_W-1:0] OFF_EN_HI    = 6'd4;
  localparam logic [ADDR_W-1:0] OFF_EN_LO    = 6'd5;
  localparam logic [ADDR_W-1:0] OFF_TYP_HI   = 6'd6;
  localparam logic [ADDR_W-1:0] OFF_TYP_LO   = 6'd7;
  localparam logic [ADDR_W-1:0] OFF_PRIO_TOP = 6'd15;
  localparam logic [ADDR_W-1:0] OFF_RAW_HI   = 6'd18;
  localparam logic [ADDR_W-1:0] OFF_RAW_LO   = 6'd19;
  localparam logic [ADDR_W-1:0] OFF_FRC_HI   = 6'd20;
  localparam logic [ADDR_W-1:0] OFF_FRC_LO   = 6'd21;
  localparam logic [ADDR_W-1:0] OFF_NRM_HI   = 6'd22;
  localparam logic [ADDR_W-1:0] OFF_NRM_LO   = 6'd23;
  localparam logic [ADDR_W-1:0] OFF_FST_HI   = 6'd24;
  localparam logic [ADDR_W-1:0] OFF_FST_LO   = 6'd25;
endpackage

// File: rtl/irq_src_state.sv
module irq_src_state #(
  parameter int DW   = irq_core_pkg::DATA_W,
  parameter int NSRC = irq_core_pkg::NUM_SRC,
  parameter int IW   = irq_core_pkg::SRC_IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [DW-1:0]   wdata,
  input  logic            en_set_we,
  input  logic            en_clr_we,
  input  logic            en_hi_we,
  input  logic            en_lo_we,
  input  logic            typ_hi_we,
  input  logic            typ_lo_we,
  input  logic            frc_hi_we,
  input  logic            frc_lo_we,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] typ_o
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] pend_q, pend_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] typ_q, typ_d;
  logic [NSRC-1:0] src_chg;
  logic            pend_ld, en_ld, typ_ld, src_ld;

  assign src_chg = src_i ^ src_q;
  assign src_ld  = |src_chg;
  assign pend_ld = src_ld | frc_hi_we | frc_lo_we;
  assign en_ld   = en_set_we | en_clr_we | en_hi_we | en_lo_we;
  assign typ_ld  = typ_hi_we | typ_lo_we;

  // Level changes first; a force write to a half takes precedence over them.
  always_comb begin
    pend_d = pend_q;
    for (int s = 0; s < NSRC; s++) begin
      if (src_chg[s]) pend_d[s] = src_i[s];
    end
    if (frc_lo_we) pend_d[DW-1:0]    = wdata;
    if (frc_hi_we) pend_d[NSRC-1:DW] = wdata;
  end

  always_comb begin
    en_d = en_q;
    if (en_set_we) en_d[wdata[IW-1:0]] = 1'b1;
    if (en_clr_we) en_d[wdata[IW-1:0]] = 1'b0;
    if (en_lo_we)  en_d[DW-1:0]        = wdata;
    if (en_hi_we)  en_d[NSRC-1:DW]     = wdata;
  end

  always_comb begin
    typ_d = typ_q;
    if (typ_lo_we) typ_d[DW-1:0]    = wdata;
    if (typ_hi_we) typ_d[NSRC-1:DW] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
      typ_q  <= '0;
    end else begin
      if (src_ld)  src_q  <= src_i;
      if (pend_ld) pend_q <= pend_d;
      if (en_ld)   en_q   <= en_d;
      if (typ_ld)  typ_q  <= typ_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign typ_o  = typ_q;
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int DW   = irq_core_pkg::DATA_W,
  parameter int PW   = irq_core_pkg::PRIO_W,
  parameter int NSRC = irq_core_pkg::NUM_SRC,
  localparam int PPW = DW / PW,
  localparam int NW  = NSRC / PPW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NW-1:0]          we,
  input  logic [DW-1:0]          wdata,
  output logic [NW-1:0][DW-1:0]  words_o,
  output logic [NSRC-1:0][PW-1:0] prio_o
);
  logic [NW-1:0][DW-1:0] word_q;

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q[w] <= '0;
      else if (we[w]) word_q[w] <= wdata;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_unpack
    assign prio_o[s] = word_q[s / PPW][(s % PPW) * PW +: PW];
  end

  assign words_o = word_q;
endmodule

// File: rtl/irq_out_decide.sv
module irq_out_decide #(
  parameter int NSRC = irq_core_pkg::NUM_SRC,
  parameter int PW   = irq_core_pkg::PRIO_W,
  parameter int TW   = irq_core_pkg::THR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         pend,
  input  logic [NSRC-1:0]         en,
  input  logic [NSRC-1:0]         typ,
  input  logic [NSRC-1:0][PW-1:0] prio,
  input  logic [TW-1:0]           thr,
  output logic                    irq_o,
  output logic                    fiq_o
);
  logic [NSRC-1:0] live_nrm, live_fst, beats_thr;
  logic            irq_d, fiq_d, irq_q, fiq_q;

  assign live_nrm = pend & en & ~typ;
  assign live_fst = pend & en & typ;

  for (genvar s = 0; s < NSRC; s++) begin : g_cmp
    assign beats_thr[s] = live_nrm[s] && ({{(TW-PW){1'b0}}, prio[s]} > thr);
  end

  always_comb begin
    fiq_d = |live_fst;
    if (thr == {TW{1'b1}}) irq_d = |live_nrm;
    else                   irq_d = |beats_thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_core_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NUM_SRC-1:0]             pend, en, typ;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [PRIO_WORDS-1:0][DATA_W-1:0] prio_words;
  logic [PRIO_WORDS-1:0]          prio_we;
  logic [THR_W-1:0]               thr_q, thr_d;
  logic                           thr_we;
  logic [DATA_W-1:0]              rd_d, rdata_q;

  assign thr_we = wr_en && (addr == OFF_THR);

  // Offset OFF_PRIO_TOP holds word 0; lower offsets hold higher words.
  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_pwe
    assign prio_we[w] = wr_en && (addr == ADDR_W'(OFF_PRIO_TOP - ADDR_W'(w)));
  end

  irq_src_state u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_i     (src_i),
    .wdata     (wdata),
    .en_set_we (wr_en && (addr == OFF_EN_SET)),
    .en_clr_we (wr_en && (addr == OFF_EN_CLR)),
    .en_hi_we  (wr_en && (addr == OFF_EN_HI)),
    .en_lo_we  (wr_en && (addr == OFF_EN_LO)),
    .typ_hi_we (wr_en && (addr == OFF_TYP_HI)),
    .typ_lo_we (wr_en && (addr == OFF_TYP_LO)),
    .frc_hi_we (wr_en && (addr == OFF_FRC_HI)),
    .frc_lo_we (wr_en && (addr == OFF_FRC_LO)),
    .pend_o    (pend),
    .en_o      (en),
    .typ_o     (typ)
  );

  irq_prio_bank u_prio (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (prio_we),
    .wdata   (wdata),
    .words_o (prio_words),
    .prio_o  (prio)
  );

  irq_out_decide u_decide (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pend  (pend),
    .en    (en),
    .typ   (typ),
    .prio  (prio),
    .thr   (thr_q),
    .irq_o (irq_o),
    .fiq_o (fiq_o)
  );

  assign thr_d = wdata[THR_W-1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  thr_q <= THR_BYPASS;
    else if (thr_we)  thr_q <= thr_d;
  end

  logic [NUM_SRC-1:0] view_nrm, view_fst;
  assign view_nrm = pend & en & ~typ;
  assign view_fst = pend & en & typ;

  always_comb begin
    rd_d = '0;
    case (addr)
      OFF_THR:    rd_d = {{(DATA_W-THR_W){1'b0}}, thr_q};
      OFF_EN_HI:  rd_d = en[NUM_SRC-1:DATA_W];
      OFF_EN_LO:  rd_d = en[DATA_W-1:0];
      OFF_TYP_HI: rd_d = typ[NUM_SRC-1:DATA_W];
      OFF_TYP_LO: rd_d = typ[DATA_W-1:0];
      OFF_RAW_HI: rd_d = pend[NUM_SRC-1:DATA_W];
      OFF_RAW_LO: rd_d = pend[DATA_W-1:0];
      OFF_NRM_HI: rd_d = view_nrm[NUM_SRC-1:DATA_W];
      OFF_NRM_LO: rd_d = view_nrm[DATA_W-1:0];
      OFF_FST_HI: rd_d = view_fst[NUM_SRC-1:DATA_W];
      OFF_FST_LO: rd_d = view_fst[DATA_W-1:0];
      default:    rd_d = '0;
    endcase
    for (int w = 0; w < PRIO_WORDS; w++) begin
      if (addr == ADDR_W'(OFF_PRIO_TOP - ADDR_W'(w))) rd_d = prio_words[w];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk
  import irq_core_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] typ,
  input logic [THR_W-1:0]   thr,
  input logic               irq_o,
  input logic               fiq_o
);
  logic frc_wr;
  assign frc_wr = wr_en && ((addr == OFF_FRC_HI) || (addr == OFF_FRC_LO));

  assert_pend_needs_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frc_wr |=> ((pend & ~$past(pend) & ~$past(src_i)) == '0));

  assert_enable_by_number_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_EN_SET) |=> en[$past(wdata[SRC_IDX_W-1:0])]);

  assert_number_regs_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == OFF_EN_SET || addr == OFF_EN_CLR)) |=> (rdata == '0));

  assert_fast_routing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == $past(|(pend & en & typ))));

  assert_bypass_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == THR_BYPASS) |=> (irq_o == $past(|(pend & en & ~typ))));

  assert_no_source_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & en & ~typ)) |=> !irq_o);

  assert_force_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == OFF_FRC_HI || addr == OFF_FRC_LO)) |=> (rdata == '0));

  assert_thr_reset_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (thr == THR_BYPASS));
endmodule

bind irq_prio_core irq_prio_core_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .src_i (src_i),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .pend  (pend),
  .en    (en),
  .typ   (typ),
  .thr   (thr_q),
  .irq_o (irq_o),
  .fiq_o (fiq_o)
);

// File: tb/irq_prio_core_test.sv
module irq_prio_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_i;
  logic        wr_en, rd_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  irq_prio_core uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_i = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(6'd1, d);  check("R9 threshold after reset", d, 32'h1F);
    rd(6'd5, d);  check("R9 enable low after reset", d, 32'h0);
    rd(6'd15, d); check("R9 priority word after reset", d, 32'h0);
    rd(6'd19, d); check("R9 pending after reset", d, 32'h0);
    check("R9 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R9 fiq after reset", {31'b0, fiq_o}, 32'h0);
  endtask

  task automatic t_enable_number();
    logic [31:0] d;
    do_reset();
    wr(6'd2, 32'd5);
    rd(6'd5, d);  check("R2 set by number low", d, 32'h0000_0020);
    wr(6'd2, 32'hFFFF_FF68);
    rd(6'd4, d);  check("R2 set by number uses low 6 bits", d, 32'h0000_0100);
    rd(6'd2, d);  check("R2 set-number reads zero", d, 32'h0);
    rd(6'd3, d);  check("R2 clear-number reads zero", d, 32'h0);
    wr(6'd3, 32'd5);
    rd(6'd5, d);  check("R2 clear by number", d, 32'h0);
    rd(6'd4, d);  check("R2 clear leaves other bit", d, 32'h0000_0100);
  endtask

  task automatic t_halves();
    logic [31:0] d;
    do_reset();
    wr(6'd5, 32'h1234_5678);
    wr(6'd4, 32'hA5A5_0000);
    rd(6'd5, d);  check("R3 enable low kept after high write", d, 32'h1234_5678);
    rd(6'd4, d);  check("R3 enable high written", d, 32'hA5A5_0000);
    wr(6'd7, 32'h0000_00F0);
    wr(6'd6, 32'h8000_0001);
    rd(6'd7, d);  check("R3 type low kept after high write", d, 32'h0000_00F0);
    rd(6'd6, d);  check("R3 type high written", d, 32'h8000_0001);
  endtask

  task automatic t_pending_level();
    logic [31:0] d;
    do_reset();
    @(negedge clk) src_i[3] = 1'b1;
    rd(6'd19, d); check("R1 pending set by high level", d, 32'h0000_0008);
    @(negedge clk) src_i[3] = 1'b0; src_i[63] = 1'b1;
    rd(6'd19, d); check("R1 pending cleared by low level", d, 32'h0);
    rd(6'd18, d); check("R1 pending high half", d, 32'h8000_0000);
  endtask

  task automatic t_fast_route();
    logic [31:0] d;
    do_reset();
    wr(6'd2, 32'd3);
    wr(6'd7, 32'h0000_0008);
    @(negedge clk) src_i[3] = 1'b1;
    settle();
    check("R4 fast output for fast source", {31'b0, fiq_o}, 32'h1);
    check("R4 normal output quiet for fast source", {31'b0, irq_o}, 32'h0);
    rd(6'd25, d); check("R4 fast view", d, 32'h0000_0008);
    rd(6'd23, d); check("R4 normal view empty", d, 32'h0);
    wr(6'd3, 32'd3);
    settle();
    check("R4 fast output drops when disabled", {31'b0, fiq_o}, 32'h0);
  endtask

  task automatic t_bypass_and_timing();
    logic [31:0] d;
    do_reset();
    wr(6'd2, 32'd3);
    settle();
    check("R5 no irq without pending", {31'b0, irq_o}, 32'h0);
    @(negedge clk) src_i[3] = 1'b1;
    @(posedge clk); #1;
    check("R12 output not yet changed at pending edge", {31'b0, irq_o}, 32'h0);
    @(posedge clk); #1;
    check("R12 output one edge after pending", {31'b0, irq_o}, 32'h1);
    check("R5 bypass with priority zero", {31'b0, irq_o}, 32'h1);
    rd(6'd23, d); check("R5 normal view", d, 32'h0000_0008);
  endtask

  task automatic t_threshold();
    do_reset();
    wr(6'd2, 32'd3);
    @(negedge clk) src_i[3] = 1'b1;
    wr(6'd1, 32'd0);
    settle();
    check("R6 priority 0 not above threshold 0", {31'b0, irq_o}, 32'h0);
    wr(6'd15, 32'h0000_1000);
    settle();
    check("R6 priority 1 above threshold 0", {31'b0, irq_o}, 32'h1);
    wr(6'd1, 32'd1);
    settle();
    check("R6 equal priority does not fire", {31'b0, irq_o}, 32'h0);
    wr(6'd15, 32'h0000_F000);
    wr(6'd1, 32'd14);
    settle();
    check("R6 priority 15 above 14", {31'b0, irq_o}, 32'h1);
    wr(6'd1, 32'd20);
    settle();
    check("R6 threshold 20 unreachable", {31'b0, irq_o}, 32'h0);
    wr(6'd1, 32'h1F);
    settle();
    check("R5 bypass value restores output", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_prio_map();
    logic [31:0] d;
    do_reset();
    wr(6'd2, 32'd63);
    @(negedge clk) src_i[63] = 1'b1;
    wr(6'd1, 32'd8);
    wr(6'd15, 32'h0000_000F);
    settle();
    check("R7 bottom word does not hold source 63", {31'b0, irq_o}, 32'h0);
    wr(6'd8, 32'h9000_0000);
    settle();
    check("R7 top word nibble 7 is source 63", {31'b0, irq_o}, 32'h1);
    rd(6'd8, d);  check("R7 word at offset 8 reads back", d, 32'h9000_0000);
    rd(6'd15, d); check("R7 word at offset 15 reads back", d, 32'h0000_000F);
    wr(6'd1, 32'd9);
    settle();
    check("R7 source 63 priority is 9", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_force_and_views();
    logic [31:0] d;
    do_reset();
    wr(6'd21, 32'h0000_0010);
    rd(6'd19, d); check("R8 force low sets pending", d, 32'h0000_0010);
    rd(6'd21, d); check("R8 force low reads zero", d, 32'h0);
    wr(6'd20, 32'h0000_0001);
    rd(6'd18, d); check("R8 force high sets pending", d, 32'h0000_0001);
    rd(6'd19, d); check("R3 force high keeps low half", d, 32'h0000_0010);
    wr(6'd2, 32'd4);
    settle();
    check("R8 forced pending drives output", {31'b0, irq_o}, 32'h1);
    wr(6'd19, 32'h0);
    wr(6'd23, 32'h0);
    wr(6'd25, 32'hFFFF_FFFF);
    rd(6'd19, d); check("R10 raw view ignores writes", d, 32'h0000_0010);
    rd(6'd23, d); check("R10 normal view ignores writes", d, 32'h0000_0010);
    rd(6'd25, d); check("R10 fast view ignores writes", d, 32'h0);
    check("R10 output unchanged after view writes", {31'b0, irq_o}, 32'h1);
    rd(6'd30, d); check("R11 unmapped reads zero", d, 32'h0);
    rd(6'd0, d);  check("R11 offset 0 reads zero", d, 32'h0);
    wr(6'd30, 32'hFFFF_FFFF);
    wr(6'd0, 32'hFFFF_FFFF);
    rd(6'd5, d);  check("R11 enable untouched by unmapped write", d, 32'h0000_0010);
    rd(6'd19, d); check("R11 pending untouched by unmapped write", d, 32'h0000_0010);
    rd(6'd7, d);  check("R11 type untouched by unmapped write", d, 32'h0);
    rd(6'd1, d);  check("R11 threshold untouched by unmapped write", d, 32'h1F);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_enable_number();
    t_halves();
    t_pending_level();
    t_fast_route();
    t_bypass_and_timing();
    t_threshold();
    t_prio_map();
    t_force_and_views();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule